// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM Controller

This block is the control and datapath of a synchronous pipelined static memory. Its word is 36 bits, split into four 9-bit byte lanes. On each rising clock edge it captures the address, the write data and every control input. Three chip enables form a device select. A global write control, a lane-write qualifier and one strobe per lane are decoded into one write enable per lane, so a single write updates any subset of the four lanes. Writes are self-timed: they are committed from the captured copy, with no further handshake.

A selected cycle that enables no lane is a read. Read data passes through an output register and is driven together with an output enable. The data pins are shared between input and output, so the output enable is high only for cycles that carry read data. After a write, or after a deselect, the output enable drops one clock later. The storage is a small behavioural array.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: A cycle is selected only when `chip_en_a_ni` and `chip_en_b_ni` are both 0 and `chip_en_c_i` is 1. In every other combination the cycle writes nothing, even if write controls are active, and it is not a read.
- R2: In a selected cycle with `wr_all_i` = 1, all four lanes of the word at `addr_i` take `wdata_i`, whatever `lane_wr_en_i` and `lane_stb_i` are.
- R3: In a selected cycle with `wr_all_i` = 0, lane k (data bits 9k+8 down to 9k) is written only when `lane_wr_en_i` = 1 and `lane_stb_i[k]` = 1. Lanes that are not written keep their contents.
- R4: A selected cycle that enables no lane is a read. If the rising edge n samples the read, then after edge n+1 `rdata_o` holds the addressed word and `rdata_oe_o` is 1. Back-to-back reads stream one word per clock.
- R5: Address and data are captured at the edge that samples the command. A read issued in the cycle right after a write to the same address returns the new data. A read issued right before such a write returns the old data.
- R6: After edge n+1, `rdata_oe_o` is 0 when edge n sampled a write cycle.
- R7: After edge n+1, `rdata_oe_o` is 0 when edge n sampled a deselected cycle. The output enable is therefore released exactly one clock after the deselect is sampled.
- R8: While `rst_ni` is 0, `rdata_oe_o` is 0 and `rdata_o` is all zeros, and no read or write is pending.
- R9: A selected cycle with `wr_all_i` = 0 and either `lane_wr_en_i` = 0 or all strobes 0 is a read. It leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_a_ni | input | 1 | Chip enable, active low |
| chip_en_b_ni | input | 1 | Chip enable, active low |
| chip_en_c_i | input | 1 | Chip enable, active high |
| addr_i | input | 6 | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| wr_all_i | input | 1 | Global write: writes all lanes |
| lane_wr_en_i | input | 1 | Qualifier for the per-lane strobes |
| lane_stb_i | input | 4 | Per-lane write strobes |
| rdata_o | output | 36 | Registered read data |
| rdata_oe_o | output | 1 | Output enable for the shared data bus |

## Verification
The checker assumes that every control input has a known 0 or 1 value at each sampling edge after reset. It also assumes that no address is read before it has been written, so read data is never undefined when compared. The stimulus meets both assumptions. Every input is driven on the falling edge from a fixed value, and the first scenario writes every address that a later read uses. A reference array in the bench holds the expected word contents. The expected read value is captured when the read is issued, so a write that follows the read does not leak into the result.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_chip_sel.sv
module sram_chip_sel (
  input  logic en_a_ni,
  input  logic en_b_ni,
  input  logic en_c_i,
  output logic sel_o
);
  assign sel_o = ~en_a_ni & ~en_b_ni & en_c_i;
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_pipe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_i,
  input  logic             wr_all_i,
  input  logic             lane_wr_en_i,
  input  logic [LANES-1:0] lane_stb_i,
  output logic [LANES-1:0] lane_we_o,
  output cyc_kind_e        kind_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // global write overrides the qualified strobe
    assign lane_we_o[g] = sel_i & (wr_all_i | (lane_wr_en_i & lane_stb_i[g]));
  end

  always_comb begin
    if (!sel_i)         kind_o = CYC_IDLE;
    else if (|lane_we_o) kind_o = CYC_WRITE;
    else                kind_o = CYC_READ;
  end
endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o   <= 1'b0;
      data_o <= '0;
    end else begin
      // enable follows the read pipeline only; writes and deselects drop it
      oe_o <= rd_i;
      if (rd_i) data_o <= rdata_i;
    end
  end
endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_pipe_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    chip_en_a_ni,
  input  logic                    chip_en_b_ni,
  input  logic                    chip_en_c_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    wr_all_i,
  input  logic                    lane_wr_en_i,
  input  logic [LANES-1:0]        lane_stb_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic             sel;
  logic [LANES-1:0] lane_we_d;
  cyc_kind_e        kind_d;

  logic [LANES-1:0]  lane_we_q;
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] core_rdata;

  sram_chip_sel u_sel (
    .en_a_ni (chip_en_a_ni),
    .en_b_ni (chip_en_b_ni),
    .en_c_i  (chip_en_c_i),
    .sel_o   (sel)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .sel_i        (sel),
    .wr_all_i     (wr_all_i),
    .lane_wr_en_i (lane_wr_en_i),
    .lane_stb_i   (lane_stb_i),
    .lane_we_o    (lane_we_d),
    .kind_o       (kind_d)
  );

  // input register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_we_q <= '0;
      kind_q    <= CYC_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      lane_we_q <= lane_we_d;
      kind_q    <= kind_d;
      addr_q    <= addr_i;
      wdata_q   <= wdata_i;
    end
  end

  sram_core #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_core (
    .clk_i     (clk_i),
    .lane_we_i (lane_we_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .rdata_o   (core_rdata)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (kind_q == CYC_READ),
    .rdata_i (core_rdata),
    .data_o  (rdata_o),
    .oe_o    (rdata_oe_o)
  );
endmodule

// File: rtl/sram_pipe_ctrl_chk.sv
module sram_pipe_ctrl_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    chip_en_a_ni,
  input logic                    chip_en_b_ni,
  input logic                    chip_en_c_i,
  input logic                    wr_all_i,
  input logic                    lane_wr_en_i,
  input logic [LANES-1:0]        lane_stb_i,
  input logic [LANES-1:0]        lane_we_q,
  input logic [LANES*LANE_W-1:0] rdata_o,
  input logic                    rdata_oe_o
);
  logic       sel_in;
  logic       wr_in;
  logic [1:0] cyc_q;

  assign sel_in = !chip_en_a_ni && !chip_en_b_ni && chip_en_c_i;
  assign wr_in  = wr_all_i || (lane_wr_en_i && (lane_stb_i != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  AST_DESEL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(!sel_in)) |-> (lane_we_q == '0)); // R1

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(sel_in && wr_all_i)) |-> (&lane_we_q)); // R2

  AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(sel_in && !wr_all_i && lane_wr_en_i)) |-> (lane_we_q == $past(lane_stb_i))); // R3

  AST_NO_QUAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(!wr_all_i && !lane_wr_en_i)) |-> (lane_we_q == '0)); // R9

  AST_OE_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (rdata_oe_o == $past(sel_in && !wr_in, 2))); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && !rdata_oe_o) |-> $stable(rdata_o)); // R4

  AST_WRITE_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && $past(sel_in && wr_in, 2)) |-> !rdata_oe_o); // R6

  AST_DESEL_OE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && $past(!sel_in, 2)) |-> !rdata_oe_o); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!rdata_oe_o && rdata_o == '0); // R8
    end
  end
endmodule

bind sram_pipe_ctrl sram_pipe_ctrl_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chip_en_a_ni (chip_en_a_ni),
  .chip_en_b_ni (chip_en_b_ni),
  .chip_en_c_i  (chip_en_c_i),
  .wr_all_i     (wr_all_i),
  .lane_wr_en_i (lane_wr_en_i),
  .lane_stb_i   (lane_stb_i),
  .lane_we_q    (lane_we_q),
  .rdata_o      (rdata_o),
  .rdata_oe_o   (rdata_oe_o)
);

// File: tb/sram_pipe_ctrl_bench.sv
module sram_pipe_ctrl_bench;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 6;
  localparam int DW     = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b1;
  logic              en_a_n = 1'b1, en_b_n = 1'b1, en_c = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              wr_all = 1'b0, lane_en = 1'b0;
  logic [LANES-1:0]  stb = '0;
  logic [DW-1:0]     rdata;
  logic              oe;

  always #10 clk = ~clk;

  sram_pipe_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_sram_pipe_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .chip_en_a_ni (en_a_n),
    .chip_en_b_ni (en_b_n),
    .chip_en_c_i  (en_c),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .wr_all_i     (wr_all),
    .lane_wr_en_i (lane_en),
    .lane_stb_i   (stb),
    .rdata_o      (rdata),
    .rdata_oe_o   (oe)
  );

  logic [DW-1:0] model [1<<ADDR_W];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    pend_rd = 0;
  logic [DW-1:0] pend_data = '0;
  string pend_tag = "";

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, then check the output produced by the previous cycle
  task automatic step(input logic an, input logic bn, input logic c, input logic gw,
                      input logic qe, input logic [LANES-1:0] s,
                      input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, input string tag);
    bit sel, wr;
    en_a_n = an; en_b_n = bn; en_c = c; wr_all = gw; lane_en = qe; stb = s;
    addr = a; wdata = d;
    @(negedge clk);
    chk(DW'(oe), DW'(pend_rd), {pend_tag, " oe"});
    if (pend_rd) chk(rdata, pend_data, {pend_tag, " data"});
    sel = !an && !bn && c;
    wr  = gw || (qe && s != '0);
    if (sel && wr) begin
      for (int l = 0; l < LANES; l++)
        if (gw || (qe && s[l])) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    end
    pend_rd   = sel && !wr;
    pend_data = model[a];
    pend_tag  = tag;
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, input string tag);
    step(0, 0, 1, 1, 0, '0, a, d, tag);
  endtask

  task automatic wr_lanes(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] s,
                          input logic [DW-1:0] d, input string tag);
    step(0, 0, 1, 0, 1, s, a, d, tag);
  endtask

  task automatic rd_word(input logic [ADDR_W-1:0] a, input string tag);
    step(0, 0, 1, 0, 0, '0, a, '0, tag);
  endtask

  task automatic desel(input string tag);
    step(1, 1, 0, 0, 0, '0, '0, '0, tag);
  endtask

  task automatic t_reset;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(DW'(oe), '0, "R8 oe in reset");
    chk(rdata, '0, "R8 data in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(DW'(oe), '0, "R8 oe after release");
  endtask

  task automatic t_global;
    for (int a = 0; a < 16; a++) wr_word(ADDR_W'(a), {4{3'(a), 6'h2a}}, "R2");
    step(0, 0, 1, 1, 1, 4'b0101, 6'd3, 36'h1_2345_6789, "R2 override");
    step(0, 0, 1, 1, 0, 4'b1111, 6'd5, 36'h9_8765_4321, "R2 override");
    for (int a = 0; a < 8; a++) rd_word(ADDR_W'(a), "R4 R2 readback");
    desel("R7");
  endtask

  task automatic t_lanes;
    wr_lanes(6'd1, 4'b0001, 36'hf_ffff_ffff, "R3 lane0");
    wr_lanes(6'd2, 4'b1010, 36'h5_5555_5555, "R3 lanes 1,3");
    wr_lanes(6'd4, 4'b1111, 36'ha_bcde_f012, "R3 all strobes");
    wr_lanes(6'd6, 4'b0110, 36'h0_0000_0000, "R3 lanes 1,2");
    wr_lanes(6'd6, 4'b1000, 36'h7_0000_0000, "R3 lane3");
    rd_word(6'd1, "R3 readback");
    rd_word(6'd2, "R3 readback");
    rd_word(6'd4, "R3 readback");
    rd_word(6'd6, "R3 readback");
    desel("R7");
  endtask

  task automatic t_no_qual;
    step(0, 0, 1, 0, 0, 4'b1111, 6'd7, 36'h0_dead_beef, "R9 strobes without qualifier");
    step(0, 0, 1, 0, 1, 4'b0000, 6'd7, 36'h0_beef_dead, "R9 qualifier without strobes");
    rd_word(6'd7, "R9 readback");
    desel("R7");
  endtask

  task automatic t_chipsel;
    for (int i = 0; i < 8; i++) begin
      if (i != 1) step(i[2], i[1], i[0], 1, 1, '1, 6'd8, 36'h3_3333_3333, "R1 deselect ignores write");
    end
    for (int i = 0; i < 8; i++) begin
      if (i != 1) step(i[2], i[1], i[0], 0, 0, '0, 6'd8, '0, "R1 deselect is no read");
    end
    rd_word(6'd8, "R1 readback");
    desel("R7");
  endtask

  task automatic t_raw;
    wr_word(6'd10, 36'h1_1111_1111, "R5 write");
    rd_word(6'd10, "R5 read after write");
    wr_lanes(6'd10, 4'b0100, 36'h2_2222_2222, "R5 lane write");
    rd_word(6'd10, "R5 read after lane write");
    rd_word(6'd10, "R5 read before write");
    wr_word(6'd10, 36'h4_4444_4444, "R5 write");
    rd_word(6'd10, "R5 read after write");
    desel("R7");
  endtask

  task automatic t_oe;
    rd_word(6'd11, "R4 stream");
    rd_word(6'd12, "R4 stream");
    wr_word(6'd12, 36'h6_6666_6666, "R6 write drops oe");
    rd_word(6'd12, "R4 after write");
    desel("R7 single-cycle deselect");
    rd_word(6'd13, "R4 after deselect");
    step(0, 0, 0, 0, 0, '0, 6'd13, '0, "R7 high enable low");
    desel("R7");
  endtask

  initial begin
    t_reset;
    t_global;
    t_lanes;
    t_no_qual;
    t_chipsel;
    t_raw;
    t_oe;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule